// File: doc/BRIEF.md
# Clock-Calendar Update Sequencer

This block keeps a time-of-day and calendar count: seconds, minutes, hours, weekday, day of month, month and a two-digit year. Once per second it advances the count by one second and carries the rollover into the higher fields. The second boundary comes from a free-running phase counter whose period, in system clock cycles, is a parameter. A simulation can therefore shorten the second to a few dozen cycles.

Software reaches every field through a byte-wide register port. Writes are synchronous and reads are combinational. Ahead of each advance a busy flag warns software that the fields are about to change, and the flag stays up through a multi-cycle update window. The counters change on the clock edge that ends the window. A one-cycle pulse then marks that the update has finished, so that an interrupt block can latch it.

A control register sets the data format (BCD or binary) and the hour format (24-hour, or 12-hour with a PM bit). It also holds a freeze bit that stops all advancing while software sets the clock.

Top module: `rtc_update_seq`

## Requirements
- R1: After reset the fields read seconds 0, minutes 0, hours 0, weekday 1, day of month 1, month 1 and year 0. The control register (address 11) reads 0x02, which means BCD, 24-hour and not frozen. The status register (address 10) reads 0.
- R2: The fields sit at these addresses: seconds 0, minutes 2, hours 4, weekday 6, day of month 7, month 8, year 9. A write to one of them takes effect at the next clock edge, and a read is combinational.
- R3: The busy flag comes out on `upd_busy` and also reads as bit 7 of address 10. It stays high for exactly LEAD_CYCLES+UPD_CYCLES consecutive cycles before each advance. It clears on the same edge that changes the fields.
- R4: `upd_done` is high for exactly one cycle, the cycle right after each advance edge.
- R5: Bit 7 of address 11 is the freeze bit. While it is set, no busy flag and no advance occur, a write to a field reads back at once, and the fields hold. Clearing the bit resumes counting from the written values.
- R6: Seconds wrap from 59 to 0 and carry into minutes. Minutes wrap from 59 to 0 and carry into hours. Hours wrap after 23 and carry into the day.
- R7: On a day carry, the weekday goes from 7 to 1 and otherwise counts up. The day of month wraps to 1 after the month's length: 30 days for months 4, 6, 9 and 11, 31 days for the other months, and for month 2 29 days when the year is divisible by 4, otherwise 28. Month wraps from 12 to 1 and carries into the year, and the year wraps from 99 to 0.
- R8: Bit 2 of address 11 selects the data format. When set, every field holds plain binary. When clear, every field holds two BCD digits, tens in bits 7:4 and units in bits 3:0.
- R9: Bit 1 of address 11 selects the hour format. When set, hours run 0 to 23. When clear, hours run 1 to 12 in bits 6:0, bit 7 is set for PM, and midnight and noon both read 12.
- R10: Address 11 keeps only bits 7, 2 and 1, and its other bits read 0. Writes to address 10 and to unmapped addresses change no state. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 4 | Register address |
| reg_wr | input | 1 | Write strobe, sampled at the clock edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| upd_busy | output | 1 | Update warning / in-progress flag |
| upd_done | output | 1 | One-cycle pulse after each advance |

## Verification
The advance logic is tried with random valid times in random formats. The bench biases these times toward 59-second, 59-minute and last-hour values so that carries occur often, and it checks every result against its own calendar model. Directed cases supply the boundaries a random draw rarely reaches: the year-end rollover, February in leap and common years, a 30-day month end, and the 12-hour transitions at 11:59:59 AM and PM. Each boundary case runs in both data formats, which separates carry errors from encoding errors. A freeze period is checked over more than two second periods, with writes landing during it. This separates a missing inhibit from a lost write. The busy flag's run length and the timing of the done pulse are measured on the first update after reset.

// File: rtl/rtc_seq_pkg.sv
package rtc_seq_pkg;

  typedef struct packed {
    logic [7:0] secs;
    logic [7:0] mins;
    logic [7:0] hrs;
    logic [7:0] wday;
    logic [7:0] mday;
    logic [7:0] mon;
    logic [7:0] yr;
  } cal_t;

  // Register byte in current format -> plain binary value
  function automatic logic [7:0] from_fmt(input logic [7:0] v, input logic bin);
    return bin ? v : (8'(v[7:4]) * 8'd10 + 8'(v[3:0]));
  endfunction

  // Plain binary value (< 100) -> register byte in current format
  function automatic logic [7:0] to_fmt(input logic [7:0] v, input logic bin);
    logic [7:0] tens;
    logic [7:0] ones;
    tens = v / 8'd10;
    ones = v % 8'd10;
    return bin ? v : {tens[3:0], ones[3:0]};
  endfunction

  // Hours register byte -> 0..23
  function automatic logic [7:0] hour_to24(input logic [7:0] raw, input logic bin,
                                           input logic h24);
    logic [7:0] h;
    if (h24) return from_fmt(raw, bin);
    h = from_fmt({1'b0, raw[6:0]}, bin);
    if (h == 8'd12) h = 8'd0;
    return raw[7] ? h + 8'd12 : h;
  endfunction

  // 0..23 -> hours register byte
  function automatic logic [7:0] hour_from24(input logic [7:0] h, input logic bin,
                                             input logic h24);
    logic [7:0] h12;
    logic [7:0] e;
    if (h24) return to_fmt(h, bin);
    h12 = (h >= 8'd12) ? h - 8'd12 : h;
    if (h12 == 8'd0) h12 = 8'd12;
    e = to_fmt(h12, bin);
    return {h >= 8'd12, e[6:0]};
  endfunction

  function automatic logic [7:0] days_in_month(input logic [7:0] mon, input logic [7:0] yr);
    case (mon)
      8'd2:                      return (yr[1:0] == 2'b00) ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11:   return 8'd30;
      default:                   return 8'd31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_tick_seq.sv
module rtc_tick_seq #(
  parameter int TICK_CYCLES = 32768,
  parameter int LEAD_CYCLES = 8,
  parameter int UPD_CYCLES  = 65
) (
  input  logic clk,
  input  logic rst_n,
  input  logic freeze,
  output logic busy,
  output logic adv,
  output logic done
);
  localparam int PH_W = $clog2(TICK_CYCLES);
  localparam logic [PH_W-1:0] LAST_PH  = PH_W'(TICK_CYCLES - 1);
  localparam logic [PH_W-1:0] ARM_PH   = PH_W'(TICK_CYCLES - LEAD_CYCLES - 1);
  localparam logic [PH_W-1:0] RISE_PH  = PH_W'(TICK_CYCLES - LEAD_CYCLES);
  localparam logic [PH_W-1:0] END_PH   = PH_W'(UPD_CYCLES - 1);
  localparam int RUN_LEN = LEAD_CYCLES + UPD_CYCLES;
  localparam int RUN_W   = $clog2(RUN_LEN + 2);

  logic [PH_W-1:0] ph;
  logic            armed;

  assign adv  = armed && !freeze && (ph == END_PH);
  assign busy = armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph    <= '0;
      armed <= 1'b0;
      done  <= 1'b0;
    end else begin
      ph   <= (ph == LAST_PH) ? '0 : ph + 1'b1;
      done <= adv;
      if (freeze)             armed <= 1'b0;
      else if (ph == ARM_PH)  armed <= 1'b1;
      else if (adv)           armed <= 1'b0;
    end
  end

  // Run-length counter of the busy flag, used by the checks only
  logic [RUN_W-1:0] run_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_len <= '0;
    else if (busy) run_len <= run_len + 1'b1;
    else           run_len <= '0;
  end

  // R3
  uip_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (ph == RISE_PH));

  // R3
  uip_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !$past(freeze)) |-> (run_len == RUN_W'(RUN_LEN)));

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5
  no_arm_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> !$rose(busy));

endmodule

// File: rtl/rtc_cal_adv.sv
module rtc_cal_adv
  import rtc_seq_pkg::*;
(
  input  cal_t cur,
  input  logic bin,
  input  logic h24,
  output cal_t nxt,
  output logic day_roll
);
  logic [7:0] s, m, h, w, d, mo, y, lim;
  logic [7:0] ns, nm, nh, nw, nd, nmo, ny;
  logic       s_roll, m_roll, h_roll, mo_roll;

  always_comb begin
    s  = from_fmt(cur.secs, bin);
    m  = from_fmt(cur.mins, bin);
    h  = hour_to24(cur.hrs, bin, h24);
    w  = from_fmt(cur.wday, bin);
    d  = from_fmt(cur.mday, bin);
    mo = from_fmt(cur.mon, bin);
    y  = from_fmt(cur.yr, bin);
    lim = days_in_month(mo, y);

    s_roll   = (s >= 8'd59);
    m_roll   = s_roll && (m >= 8'd59);
    h_roll   = m_roll && (h >= 8'd23);
    day_roll = h_roll && (d >= lim);
    mo_roll  = day_roll && (mo >= 8'd12);

    ns  = s_roll ? 8'd0 : s + 8'd1;
    nm  = m_roll ? 8'd0 : (s_roll ? m + 8'd1 : m);
    nh  = h_roll ? 8'd0 : (m_roll ? h + 8'd1 : h);
    nw  = h_roll ? ((w >= 8'd7) ? 8'd1 : w + 8'd1) : w;
    nd  = day_roll ? 8'd1 : (h_roll ? d + 8'd1 : d);
    nmo = mo_roll ? 8'd1 : (day_roll ? mo + 8'd1 : mo);
    ny  = mo_roll ? ((y >= 8'd99) ? 8'd0 : y + 8'd1) : y;

    nxt.secs = to_fmt(ns, bin);
    nxt.mins = to_fmt(nm, bin);
    nxt.hrs  = hour_from24(nh, bin, h24);
    nxt.wday = to_fmt(nw, bin);
    nxt.mday = to_fmt(nd, bin);
    nxt.mon  = to_fmt(nmo, bin);
    nxt.yr   = to_fmt(ny, bin);
  end
endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
  import rtc_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] addr,
  input  logic       wr,
  input  logic [7:0] wdata,
  input  logic       adv,
  input  cal_t       nxt,
  input  logic       busy,
  output cal_t       cal_q,
  output logic       set_q,
  output logic       bin_q,
  output logic       h24_q,
  output logic [7:0] rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cal_q <= '{secs: 8'd0, mins: 8'd0, hrs: 8'd0, wday: 8'd1,
                 mday: 8'd1, mon: 8'd1, yr: 8'd0};
      set_q <= 1'b0;
      bin_q <= 1'b0;
      h24_q <= 1'b1;
    end else begin
      if (adv) cal_q <= nxt;
      if (wr) begin
        case (addr)
          4'd0:  cal_q.secs <= wdata;
          4'd2:  cal_q.mins <= wdata;
          4'd4:  cal_q.hrs  <= wdata;
          4'd6:  cal_q.wday <= wdata;
          4'd7:  cal_q.mday <= wdata;
          4'd8:  cal_q.mon  <= wdata;
          4'd9:  cal_q.yr   <= wdata;
          4'd11: begin
            set_q <= wdata[7];
            bin_q <= wdata[2];
            h24_q <= wdata[1];
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (addr)
      4'd0:    rdata = cal_q.secs;
      4'd2:    rdata = cal_q.mins;
      4'd4:    rdata = cal_q.hrs;
      4'd6:    rdata = cal_q.wday;
      4'd7:    rdata = cal_q.mday;
      4'd8:    rdata = cal_q.mon;
      4'd9:    rdata = cal_q.yr;
      4'd10:   rdata = {busy, 7'd0};
      4'd11:   rdata = {set_q, 4'd0, bin_q, h24_q, 1'b0};
      default: rdata = 8'd0;
    endcase
  end

  // R5
  frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_q && !wr) |=> $stable(cal_q));

  // R6
  sec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !wr) |=> (bin_q ? (cal_q.secs < 8'd60) : (cal_q.secs[7:4] < 4'd6)));

endmodule

// File: rtl/rtc_update_seq.sv
module rtc_update_seq
  import rtc_seq_pkg::*;
#(
  parameter int TICK_CYCLES = 32768,
  parameter int LEAD_CYCLES = 8,
  parameter int UPD_CYCLES  = 65
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] reg_addr,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       upd_busy,
  output logic       upd_done
);
  cal_t cal_q, cal_nxt;
  logic set_q, bin_q, h24_q;
  logic adv;
  logic day_roll;

  rtc_tick_seq #(
    .TICK_CYCLES(TICK_CYCLES),
    .LEAD_CYCLES(LEAD_CYCLES),
    .UPD_CYCLES (UPD_CYCLES)
  ) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .freeze(set_q),
    .busy  (upd_busy),
    .adv   (adv),
    .done  (upd_done)
  );

  rtc_cal_adv u_adv (
    .cur     (cal_q),
    .bin     (bin_q),
    .h24     (h24_q),
    .nxt     (cal_nxt),
    .day_roll(day_roll)
  );

  rtc_regfile u_regs (
    .clk  (clk),
    .rst_n(rst_n),
    .addr (reg_addr),
    .wr   (reg_wr),
    .wdata(reg_wdata),
    .adv  (adv),
    .nxt  (cal_nxt),
    .busy (upd_busy),
    .cal_q(cal_q),
    .set_q(set_q),
    .bin_q(bin_q),
    .h24_q(h24_q),
    .rdata(reg_rdata)
  );

  // R7
  day_roll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && day_roll && !reg_wr) |=> (cal_q.mday == 8'd1));

endmodule

// File: tb/rtc_update_seq_test.sv
module rtc_update_seq_test;
  localparam int P = 64;
  localparam int L = 5;
  localparam int U = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] addr = '0;
  logic       wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       busy, done;

  always #2 clk = ~clk;

  rtc_update_seq #(.TICK_CYCLES(P), .LEAD_CYCLES(L), .UPD_CYCLES(U)) uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(addr), .reg_wr(wr), .reg_wdata(wdata),
    .reg_rdata(rdata), .upd_busy(busy), .upd_done(done)
  );

  int checks = 0, failures = 0;
  bit finished = 0;
  int t[7];                       // sec, min, hour(0..23), wday, mday, month, year
  int fa[7] = '{0, 2, 4, 6, 7, 8, 9};

  function automatic int enc(int v, bit bin);
    return bin ? v : ((v / 10) << 4) | (v % 10);
  endfunction

  function automatic int enc_hr(int h, bit bin, bit h24);
    int hh;
    if (h24) return enc(h, bin);
    hh = h % 12;
    if (hh == 0) hh = 12;
    return enc(hh, bin) | ((h >= 12) ? 8'h80 : 0);
  endfunction

  function automatic int enc_field(int i, int v, bit bin, bit h24);
    return (i == 2) ? enc_hr(v, bin, h24) : enc(v, bin);
  endfunction

  function automatic int mlen(int mo, int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic step_ref();
    t[0]++;
    if (t[0] < 60) return;
    t[0] = 0; t[1]++;
    if (t[1] < 60) return;
    t[1] = 0; t[2]++;
    if (t[2] < 24) return;
    t[2] = 0;
    t[3] = (t[3] == 7) ? 1 : t[3] + 1;
    t[4]++;
    if (t[4] <= mlen(t[5], t[6])) return;
    t[4] = 1; t[5]++;
    if (t[5] <= 12) return;
    t[5] = 1; t[6] = (t[6] + 1) % 100;
  endtask

  task automatic check(int act, int exp, string tag);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(int a, int d);
    @(negedge clk);
    addr = 4'(a); wdata = 8'(d); wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(int a, output int v);
    @(negedge clk);
    addr = 4'(a);
    #1 v = int'(rdata);
  endtask

  task automatic wait_done(output bit ok);
    ok = 0;
    for (int k = 0; k < 4 * P; k++) begin
      @(negedge clk);
      if (done) begin ok = 1; break; end
    end
  endtask

  task automatic load(bit bin, bit h24);
    int v;
    wr_reg(11, 8'h80 | (bin << 2) | (h24 << 1));
    for (int i = 0; i < 7; i++) wr_reg(fa[i], enc_field(i, t[i], bin, h24));
    rd_reg(0, v);
    check(v, enc(t[0], bin), "R5 frozen write readback");
    wr_reg(11, (bin << 2) | (h24 << 1));
  endtask

  task automatic advance_and_verify(bit bin, bit h24, string tag);
    bit ok;
    int v;
    load(bin, h24);
    step_ref();
    wait_done(ok);
    check(int'(ok), 1, {tag, " update occurs"});
    for (int i = 0; i < 7; i++) begin
      rd_reg(fa[i], v);
      check(v, enc_field(i, t[i], bin, h24), tag);
    end
  endtask

  task automatic set_t(int s, int mi, int h, int w, int d, int mo, int y);
    t[0] = s; t[1] = mi; t[2] = h; t[3] = w; t[4] = d; t[5] = mo; t[6] = y;
  endtask

  initial begin
    int v, cnt;
    bit ok, seen_bit, quiet;
    int exp_rst[7] = '{0, 0, 0, 1, 1, 1, 0};
    void'($urandom(32'd1234));

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    for (int i = 0; i < 7; i++) begin
      rd_reg(fa[i], v);
      check(v, exp_rst[i], "R1 reset field");
    end
    rd_reg(11, v); check(v, 8'h02, "R1 reset control");
    rd_reg(10, v); check(v, 0, "R1 reset status");

    // R3/R4 first update after reset, address 10 selected
    @(negedge clk); addr = 4'd10;
    cnt = 0; seen_bit = 0;
    for (int k = 0; k < 2 * P && !busy; k++) @(negedge clk);
    while (busy && cnt < 4 * P) begin
      #1 if (rdata[7]) seen_bit = 1;
      cnt++;
      @(negedge clk);
    end
    check(cnt, L + U, "R3 busy run length");
    check(int'(seen_bit), 1, "R3 busy visible at address 10");
    check(int'(done), 1, "R4 done after advance");
    addr = 4'd0;
    #1 check(int'(rdata), 1, "R6 R2 seconds advanced at busy fall");
    @(negedge clk);
    check(int'(done), 0, "R4 done one cycle");

    // R5 freeze and R10 ignored writes
    wr_reg(11, 8'h82);
    wr_reg(0, 8'h45);
    rd_reg(0, v); check(v, 8'h45, "R5 write lands when frozen");
    quiet = 1;
    for (int k = 0; k < 2 * P + 5; k++) begin
      @(negedge clk);
      if (busy || done) quiet = 0;
    end
    check(int'(quiet), 1, "R5 no busy or done while frozen");
    rd_reg(0, v); check(v, 8'h45, "R5 fields hold while frozen");
    wr_reg(1, 8'h33);
    wr_reg(10, 8'h7F);
    rd_reg(1, v); check(v, 0, "R10 unmapped reads 0");
    rd_reg(10, v); check(v, 0, "R10 status write ignored");
    rd_reg(0, v); check(v, 8'h45, "R10 stray writes leave seconds");
    wr_reg(11, 8'hFD);
    rd_reg(11, v); check(v, 8'h84, "R10 control keeps bits 7,2,1");

    // Directed carries in both formats
    for (int b = 0; b < 2; b++) begin
      set_t(59, 59, 23, 7, 31, 12, 99); advance_and_verify(b[0], 1, "R7 R6 R8 year end");
      set_t(59, 59, 23, 3, 28, 2, 4);   advance_and_verify(b[0], 1, "R7 leap feb 28");
      set_t(59, 59, 23, 3, 28, 2, 3);   advance_and_verify(b[0], 1, "R7 common feb 28");
      set_t(59, 59, 23, 4, 29, 2, 8);   advance_and_verify(b[0], 1, "R7 leap feb 29");
      set_t(59, 59, 23, 5, 30, 4, 21);  advance_and_verify(b[0], 1, "R7 april end");
      set_t(59, 59, 11, 2, 10, 6, 50);  advance_and_verify(b[0], 0, "R9 11:59:59 AM");
      set_t(59, 59, 23, 2, 10, 6, 50);  advance_and_verify(b[0], 0, "R9 11:59:59 PM");
      set_t(59, 59, 12, 2, 10, 6, 50);  advance_and_verify(b[0], 0, "R9 12:59:59 PM");
      set_t(30, 59, 9, 6, 15, 7, 42);   advance_and_verify(b[0], 1, "R6 no carry");
    end

    // Random valid times with carry bias
    for (int n = 0; n < 40; n++) begin
      bit rb, rh;
      rb = 1'($urandom);
      rh = 1'($urandom);
      t[6] = $urandom % 100;
      t[5] = 1 + $urandom % 12;
      t[4] = ($urandom % 3 == 0) ? mlen(t[5], t[6]) : 1 + $urandom % mlen(t[5], t[6]);
      t[3] = 1 + $urandom % 7;
      t[2] = ($urandom % 2 == 0) ? 23 : $urandom % 24;
      t[1] = ($urandom % 2 == 0) ? 59 : $urandom % 60;
      t[0] = ($urandom % 4 != 0) ? 59 : $urandom % 60;
      advance_and_verify(rb, rh, "R6 R7 R8 R9 random");
    end

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog R3 actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule